// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits between several processors and a shared memory. It decides whether each store-exclusive may write. Every processor issues load-exclusive, store-exclusive, clear-exclusive and ordinary store requests. Each request carries a physical address, an access size and a shared-attribute bit. One cycle later the block answers with a one-bit status, 0 for success and 1 for failure, and with a write-enable that the memory side uses to commit or drop the exclusive store.

The block keeps two levels of reservation for each processor. A local flag covers non-shared addresses and records only that an exclusive load is outstanding. An address tag covers shared addresses and names one doubleword-aligned granule. A new shared load-exclusive moves the tag to the new granule. When another processor writes to a shared granule, whether by an ordinary store or by a winning exclusive store, any tag that names that granule is cleared.

The request channel never applies back-pressure. Every request is accepted in the cycle its valid is high. The response channel has valid but no ready, so the receiver must take each response in the cycle it appears.

Top module: `excl_monitor`

## Requirements
- R1: After reset every processor is Open with no valid tag and no response pending, so a store-exclusive issued before any load-exclusive returns status 1.
- R2: A request in cycle t produces a response with rsp_valid high in cycle t+1 on the same processor's lane. Load-exclusive (op 01), clear-exclusive (op 11) and ordinary store (op 00) responses carry status 0 and write-enable 0.
- R3: Any store-exclusive (op 10) returns that processor to Open and drops its tag, so a second store-exclusive without a new load-exclusive fails.
- R4: A shared store-exclusive succeeds only when the processor's tag names the same granule, where the granule is address bits [31:3]. A store to another granule fails.
- R5: A shared load-exclusive replaces any earlier tag, so a store-exclusive to the earlier granule then fails.
- R6: A clear-exclusive makes the next store-exclusive fail, for both shared and non-shared addresses, without a memory write.
- R7: A successful store-exclusive gives status 0 and write-enable 1. A failed one gives status 1 and write-enable 0.
- R8: A shared ordinary store, or a winning shared store-exclusive, by one processor clears the tag of every other processor that names the same granule. A tag on a different granule survives.
- R9: When several processors issue store-exclusives that would succeed on the same shared granule in one cycle, only the lowest-numbered one succeeds. Store-exclusives to different granules in the same cycle all succeed.
- R10: A store-exclusive whose address is not aligned to its size fails. Size 00 is byte, 01 is halfword (bit 0 must be 0), 10 is word (bits 1:0 must be 0) and 11 is doubleword (bits 2:0 must be 0). Such a store still returns the processor to Open.
- R11: A non-shared store-exclusive succeeds after a non-shared load-exclusive whatever its address, because the local flag carries no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_CPU | Request valid, one bit per processor |
| req_op | input | N_CPU x 2 | Operation: 00 store, 01 load-exclusive, 10 store-exclusive, 11 clear |
| req_addr | input | N_CPU x ADDR_W | Physical address |
| req_size | input | N_CPU x 2 | Access size: 00 byte, 01 half, 10 word, 11 double |
| req_shared | input | N_CPU | Shared attribute of the address |
| rsp_valid | output | N_CPU | Response valid, one cycle after the request |
| rsp_status | output | N_CPU | 0 success, 1 failure |
| rsp_wr_ok | output | N_CPU | Memory may perform the exclusive store |

## Verification
Every response arrives exactly one cycle after its request, because status, write-enable and response valid are each one register stage behind the inputs. Reservation state changes take effect at the same clock edge, so a follow-up request sees them at the very next edge. The driver pushes each expectation when it presents a request. The monitor samples on the falling edge that follows the capturing rising edge and pops one item for each valid response lane. Extra, missing and reordered responses therefore all show up as mismatches.

// File: rtl/excl_pkg.sv
package excl_pkg;
  localparam int GRAN_LSB = 3;

  typedef enum logic [1:0] {
    OP_STORE = 2'b00,
    OP_LDX   = 2'b01,
    OP_STX   = 2'b10,
    OP_CLR   = 2'b11
  } excl_op_e;

  // Natural alignment: low address bits below the access size must be zero.
  function automatic logic size_aligned(input logic [2:0] lo, input logic [1:0] sz);
    logic [2:0] mask;
    case (sz)
      2'b00:   mask = 3'b000;
      2'b01:   mask = 3'b001;
      2'b10:   mask = 3'b011;
      default: mask = 3'b111;
    endcase
    return (lo & mask) == 3'b000;
  endfunction
endpackage

// File: rtl/excl_slot.sv
module excl_slot
  import excl_pkg::*;
#(
  parameter int GW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [GW-1:0] req_gran,
  input  logic          req_shared,
  input  logic          req_aligned,
  input  logic          grant,
  input  logic          snoop_clr,
  output logic          pass_raw,
  output logic          tag_valid,
  output logic [GW-1:0] tag_gran,
  output logic          rsp_valid,
  output logic          rsp_status,
  output logic          rsp_wr_ok
);
  logic local_excl;
  logic is_stx;

  assign is_stx = req_valid && (req_op == OP_STX);

  always_comb begin
    if (req_shared) pass_raw = is_stx && req_aligned && tag_valid && (tag_gran == req_gran);
    else            pass_raw = is_stx && req_aligned && local_excl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 1'b0;
      rsp_wr_ok  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_status <= is_stx && !grant;
      rsp_wr_ok  <= grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_excl <= 1'b0;
      tag_valid  <= 1'b0;
      tag_gran   <= '0;
    end else begin
      if (snoop_clr) tag_valid <= 1'b0;
      if (req_valid) begin
        case (req_op)
          OP_LDX: begin
            local_excl <= 1'b1;
            if (req_shared) begin
              tag_valid <= 1'b1;
              tag_gran  <= req_gran;
            end
          end
          OP_STX, OP_CLR: begin
            local_excl <= 1'b0;
            tag_valid  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/excl_arbiter.sv
module excl_arbiter
  import excl_pkg::*;
#(
  parameter int N_CPU = 2,
  parameter int GW    = 29
) (
  input  logic [N_CPU-1:0]         req_valid,
  input  logic [N_CPU-1:0][1:0]    req_op,
  input  logic [N_CPU-1:0]         req_shared,
  input  logic [N_CPU-1:0][GW-1:0] req_gran,
  input  logic [N_CPU-1:0]         pass_raw,
  input  logic [N_CPU-1:0]         tag_valid,
  input  logic [N_CPU-1:0][GW-1:0] tag_gran,
  output logic [N_CPU-1:0]         grant,
  output logic [N_CPU-1:0]         snoop_clr
);
  logic [N_CPU-1:0] wr_hit;

  // Lower index wins a shared granule contested in the same cycle.
  always_comb begin
    for (int i = 0; i < N_CPU; i++) begin
      grant[i] = pass_raw[i];
      for (int j = 0; j < i; j++) begin
        if (pass_raw[j] && req_shared[j] && req_shared[i] && (req_gran[j] == req_gran[i]))
          grant[i] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < N_CPU; j++)
      wr_hit[j] = req_valid[j] && req_shared[j] && ((req_op[j] == OP_STORE) || grant[j]);
  end

  always_comb begin
    for (int k = 0; k < N_CPU; k++) begin
      snoop_clr[k] = 1'b0;
      for (int j = 0; j < N_CPU; j++) begin
        if (j != k && wr_hit[j] && tag_valid[k] && (req_gran[j] == tag_gran[k]))
          snoop_clr[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_CPU-1:0]             req_valid,
  input  logic [N_CPU-1:0][1:0]        req_op,
  input  logic [N_CPU-1:0][ADDR_W-1:0] req_addr,
  input  logic [N_CPU-1:0][1:0]        req_size,
  input  logic [N_CPU-1:0]             req_shared,
  output logic [N_CPU-1:0]             rsp_valid,
  output logic [N_CPU-1:0]             rsp_status,
  output logic [N_CPU-1:0]             rsp_wr_ok
);
  localparam int GW = ADDR_W - GRAN_LSB;

  logic [N_CPU-1:0][GW-1:0] gran;
  logic [N_CPU-1:0]         aligned;
  logic [N_CPU-1:0]         pass_raw;
  logic [N_CPU-1:0]         grant;
  logic [N_CPU-1:0]         snoop_clr;
  logic [N_CPU-1:0]         tag_valid;
  logic [N_CPU-1:0][GW-1:0] tag_gran;

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    assign gran[c]    = req_addr[c][ADDR_W-1:GRAN_LSB];
    assign aligned[c] = size_aligned(req_addr[c][GRAN_LSB-1:0], req_size[c]);

    excl_slot #(.GW(GW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[c]),
      .req_op     (req_op[c]),
      .req_gran   (gran[c]),
      .req_shared (req_shared[c]),
      .req_aligned(aligned[c]),
      .grant      (grant[c]),
      .snoop_clr  (snoop_clr[c]),
      .pass_raw   (pass_raw[c]),
      .tag_valid  (tag_valid[c]),
      .tag_gran   (tag_gran[c]),
      .rsp_valid  (rsp_valid[c]),
      .rsp_status (rsp_status[c]),
      .rsp_wr_ok  (rsp_wr_ok[c])
    );
  end

  excl_arbiter #(.N_CPU(N_CPU), .GW(GW)) u_arb (
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_shared(req_shared),
    .req_gran  (gran),
    .pass_raw  (pass_raw),
    .tag_valid (tag_valid),
    .tag_gran  (tag_gran),
    .grant     (grant),
    .snoop_clr (snoop_clr)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int N_CPU  = 2,
  parameter int ADDR_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_CPU-1:0]             req_valid,
  input logic [N_CPU-1:0][1:0]        req_op,
  input logic [N_CPU-1:0][ADDR_W-1:0] req_addr,
  input logic [N_CPU-1:0][1:0]        req_size,
  input logic [N_CPU-1:0]             req_shared,
  input logic [N_CPU-1:0]             rsp_valid,
  input logic [N_CPU-1:0]             rsp_status,
  input logic [N_CPU-1:0]             rsp_wr_ok
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (rsp_valid == '0));

  for (genvar i = 0; i < N_CPU; i++) begin : g_lane
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] |=> rsp_valid[i]);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[i] |=> !rsp_valid[i]);
    // R2
    wr_only_for_stx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wr_ok[i] |-> (rsp_valid[i] && $past(req_op[i]) == 2'b10));
    // R7
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && rsp_status[i]) |-> !rsp_wr_ok[i]);
    // R6
    clear_then_stx_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_op[i] == 2'b10 && $past(req_valid[i] && req_op[i] == 2'b11))
        |=> (rsp_status[i] && !rsp_wr_ok[i]));
    // R10
    misaligned_double_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_op[i] == 2'b10 && req_size[i] == 2'b11 && req_addr[i][2:0] != 3'b000)
        |=> !rsp_wr_ok[i]);
    for (genvar j = i + 1; j < N_CPU; j++) begin : g_pair
      // R9
      single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_wr_ok[i] && rsp_wr_ok[j]) |->
          !$past(req_shared[i] && req_shared[j] &&
                 req_addr[i][ADDR_W-1:3] == req_addr[j][ADDR_W-1:3]));
    end
  end
endmodule

bind excl_monitor excl_monitor_chk #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_size(req_size), .req_shared(req_shared),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_wr_ok(rsp_wr_ok)
);

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  localparam int N = 2;
  localparam logic [31:0] A  = 32'h0000_1000;
  localparam logic [31:0] A4 = 32'h0000_1004;
  localparam logic [31:0] B  = 32'h0000_2000;

  typedef struct {
    bit    st;
    bit    wr;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]       req_valid = '0;
  logic [N-1:0][1:0]  req_op = '0;
  logic [N-1:0][31:0] req_addr = '0;
  logic [N-1:0][1:0]  req_size = '0;
  logic [N-1:0]       req_shared = '0;
  logic [N-1:0]       rsp_valid, rsp_status, rsp_wr_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  exp_t q[N][$];

  always #10 clk = ~clk;

  excl_monitor #(.N_CPU(N), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_shared(req_shared),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_wr_ok(rsp_wr_ok)
  );

  task automatic put(input int c, input logic [1:0] op, input logic [31:0] a,
                     input logic sh, input logic [1:0] sz, input bit est, input bit ewr,
                     input string tag);
    exp_t e;
    req_valid[c] = 1'b1; req_op[c] = op; req_addr[c] = a;
    req_shared[c] = sh; req_size[c] = sz;
    e.st = est; e.wr = ewr; e.tag = tag;
    q[c].push_back(e);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    req_valid = '0;
  endtask

  task automatic ldx(input int c, input logic [31:0] a, input logic sh, input string tag);
    put(c, 2'b01, a, sh, 2'b10, 1'b0, 1'b0, tag); step();
  endtask

  task automatic stx(input int c, input logic [31:0] a, input logic sh, input logic [1:0] sz,
                     input bit ok, input string tag);
    put(c, 2'b10, a, sh, sz, !ok, ok, tag); step();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < N; c++) begin
        if (rsp_valid[c]) begin
          n_chk++;
          if (q[c].size() == 0) begin
            n_fail++;
            $display("FAIL R2 cpu%0d: unexpected response st=%0b wr=%0b, expected none",
                     c, rsp_status[c], rsp_wr_ok[c]);
          end else begin
            exp_t e;
            e = q[c].pop_front();
            if (rsp_status[c] !== e.st || rsp_wr_ok[c] !== e.wr) begin
              n_fail++;
              $display("FAIL %s cpu%0d: st=%0b wr=%0b, expected st=%0b wr=%0b",
                       e.tag, c, rsp_status[c], rsp_wr_ok[c], e.st, e.wr);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== '0) begin
      n_fail++;
      $display("FAIL R1: rsp_valid=%b, expected 00", rsp_valid);
    end
    // R1: store-exclusive with no prior load-exclusive fails
    stx(0, A, 1'b1, 2'b10, 1'b0, "R1");
    stx(1, A, 1'b0, 2'b10, 1'b0, "R1");
    // R11 / R3: non-shared flag carries no address; second stx fails
    ldx(0, A, 1'b0, "R2");
    stx(0, B, 1'b0, 2'b10, 1'b1, "R11");
    stx(0, B, 1'b0, 2'b10, 1'b0, "R3");
    // R4: same granule succeeds, other granule fails
    ldx(0, A, 1'b1, "R2");
    stx(0, A4, 1'b1, 2'b10, 1'b1, "R4");
    ldx(0, A, 1'b1, "R2");
    stx(0, B, 1'b1, 2'b10, 1'b0, "R4");
    // R5: new load-exclusive moves the tag
    ldx(0, A, 1'b1, "R2");
    ldx(0, B, 1'b1, "R2");
    stx(0, A, 1'b1, 2'b10, 1'b0, "R5");
    // R6: clear-exclusive, shared and non-shared
    ldx(0, A, 1'b1, "R2");
    put(0, 2'b11, A, 1'b1, 2'b10, 1'b0, 1'b0, "R2"); step();
    stx(0, A, 1'b1, 2'b10, 1'b0, "R6");
    ldx(1, B, 1'b0, "R2");
    put(1, 2'b11, B, 1'b0, 2'b10, 1'b0, 1'b0, "R2"); step();
    stx(1, B, 1'b0, 2'b10, 1'b0, "R6");
    // R8: plain shared store by other cpu clears matching tag only
    ldx(0, A, 1'b1, "R2");
    put(1, 2'b00, A4, 1'b1, 2'b10, 1'b0, 1'b0, "R2"); step();
    stx(0, A, 1'b1, 2'b10, 1'b0, "R8");
    ldx(0, A, 1'b1, "R2");
    put(1, 2'b00, B, 1'b1, 2'b10, 1'b0, 1'b0, "R2"); step();
    stx(0, A, 1'b1, 2'b10, 1'b1, "R8");
    // R8: winning store-exclusive by cpu1 clears cpu0's tag
    ldx(0, A, 1'b1, "R2");
    ldx(1, A, 1'b1, "R2");
    stx(1, A, 1'b1, 2'b10, 1'b1, "R8");
    stx(0, A, 1'b1, 2'b10, 1'b0, "R8");
    // R9: same-cycle contention, lower index wins
    ldx(0, A, 1'b1, "R2");
    ldx(1, A, 1'b1, "R2");
    put(0, 2'b10, A, 1'b1, 2'b10, 1'b0, 1'b1, "R9");
    put(1, 2'b10, A, 1'b1, 2'b10, 1'b1, 1'b0, "R9");
    step();
    // R9: different granules in the same cycle both succeed
    ldx(0, A, 1'b1, "R2");
    ldx(1, B, 1'b1, "R2");
    put(0, 2'b10, A, 1'b1, 2'b10, 1'b0, 1'b1, "R9");
    put(1, 2'b10, B, 1'b1, 2'b10, 1'b0, 1'b1, "R9");
    step();
    // R10: alignment
    ldx(0, A, 1'b1, "R2");
    stx(0, A + 32'd2, 1'b1, 2'b10, 1'b0, "R10");
    stx(0, A, 1'b1, 2'b10, 1'b0, "R10");
    ldx(0, A, 1'b1, "R2");
    stx(0, A + 32'd1, 1'b1, 2'b00, 1'b1, "R10");
    ldx(0, A, 1'b1, "R2");
    stx(0, A4, 1'b1, 2'b11, 1'b0, "R10");
    ldx(1, A, 1'b1, "R2");
    stx(1, A, 1'b1, 2'b11, 1'b1, "R10");
    step();
    for (int c = 0; c < N; c++) begin
      n_chk++;
      if (q[c].size() != 0) begin
        n_fail++;
        $display("FAIL R2 cpu%0d: %0d responses missing, expected 0", c, q[c].size());
      end
    end
    summary();
  end
endmodule